// File: doc/BRIEF.md
# Phase-Interleaved Dual-Core Memory Fabric

This block lets two 8-bit cores share one clock. A phase bit flips on every fabric clock edge. While the phase is 0, core 0 owns the memory path. While it is 1, core 1 owns it. In each phase the fabric takes the owning core's address, write strobe and write data. It routes them to four synchronous banks, to a read-only identity location or to a peripheral window. The non-owning core's bus inputs are ignored for that cycle.

Each core has a private bank, which holds its stack. There are also two crossover banks. Crossover bank k can only be written by core k and can only be read by the other core. Because of this split, the two cores can issue back-to-back writes on alternating phases and no write ever lands in memory owned by the other writer.

Peripherals are reachable only from one fixed phase, so their timers always see the same core. The peripheral interrupt line is routed to one designated core only.

Top module: `dual_phase_mem_fabric`

## Requirements
- R1: `phase` is 0 during and right after reset and flips on every clock edge after that. Core c's `addr`, `we` and `wdata` are used only in cycles where `phase == c`. In any other cycle they have no effect, whatever their value, including `we = 1`.
- R2: `cN_rdata` resets to 0. It is loaded only at the edge that ends a read (`we = 0`) in core N's phase. It holds its value through the other core's phase and through core N's write cycles.
- R3: Addresses 0x0000–0x3FFF map to the core's own private bank. The bank index is the low BANK_AW address bits, so the bank repeats through the window. The other core cannot read or write this bank.
- R4: Core c writing to 0x4000–0x5FFF stores into crossover bank c, indexed by the low BANK_AW bits. Core c reading 0x6000–0x7FFF returns crossover bank (1−c) at the same index.
- R5: A read from a core's own write window (0x4000–0x5FFF) returns all ones.
- R6: A write to a core's read window (0x6000–0x7FFF) changes no memory. It sets that core's `cN_viol` flag. The flag stays set until reset, and the other core's flag is not affected.
- R7: A read of 0xFFF0 returns the reading core's index, zero-extended (core 0 gets 0x00, core 1 gets 0x01). Writes to 0xFFF0 have no effect.
- R8: Addresses 0x8000–0x80FF form the peripheral window. Only core IO_CORE (default 0) can reach it. In that core's phase, `io_sel` is high, `io_addr` carries address bits 7:0 and `io_we` follows `we`. A read from this window returns `io_rdata`. For the other core, `io_sel` stays low, reads return all ones and writes do nothing.
- R9: `irq_in` drives the `irq` output of core IRQ_CORE (default 0) directly. The other core's `irq` output is always 0.
- R10: Every other address reads as all ones. Writes to these addresses change nothing and raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, one edge per phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase | output | 1 | Index of the core that owns the current cycle |
| c0_addr | input | 16 | Core 0 address |
| c0_we | input | 1 | Core 0 write strobe |
| c0_wdata | input | DATA_W | Core 0 write data |
| c0_rdata | output | DATA_W | Core 0 read data |
| c0_viol | output | 1 | Core 0 sticky flag for a write to its read window |
| c0_irq | output | 1 | Core 0 interrupt request |
| c1_addr | input | 16 | Core 1 address |
| c1_we | input | 1 | Core 1 write strobe |
| c1_wdata | input | DATA_W | Core 1 write data |
| c1_rdata | output | DATA_W | Core 1 read data |
| c1_viol | output | 1 | Core 1 sticky flag for a write to its read window |
| c1_irq | output | 1 | Core 1 interrupt request |
| irq_in | input | 1 | Peripheral interrupt request |
| io_sel | output | 1 | Peripheral window select |
| io_addr | output | 8 | Peripheral register address |
| io_we | output | 1 | Peripheral write strobe |
| io_wdata | output | DATA_W | Peripheral write data |
| io_rdata | input | DATA_W | Peripheral read data |

## Verification
The fabric is tested with three kinds of traffic.

- **Full fill of all four banks.** Both cores write in alternating phases across every index of every bank. Every later read therefore compares against known contents, and a write that goes to the wrong bank or the wrong index shows up as a mismatch.
- **Long random stream.** Each core runs a random mix of reads and writes over all regions. In the phase it does not own, each core drives random addresses with the write strobe high. Any leakage of the idle core's bus shows up later as corrupted contents or as a wrong peripheral write count.
- **Directed cases.** These cover the remaining corners:
  - both cores writing the same crossover index back-to-back, then each core reading back the other's value;
  - reads from a core's own write window;
  - illegal writes that must set only the writer's flag;
  - private-bank repetition across the window;
  - identity reads from both phases;
  - peripheral access from the core that does not own it;
  - unmapped addresses;
  - interrupt routing.

// File: rtl/fabric_pkg.sv
package fabric_pkg;

   localparam int ADDR_W = 16;
   localparam logic [ADDR_W-1:0] ID_ADDR = 16'hFFF0;

   typedef enum logic [2:0] {
      RG_PRIV,
      RG_OWN_WR,
      RG_PEER_RD,
      RG_IO,
      RG_ID,
      RG_NONE
   } region_e;

   function automatic region_e decode_region(input logic [ADDR_W-1:0] a);
      if (a[15:14] == 2'b00)      return RG_PRIV;
      else if (a[15:13] == 3'b010) return RG_OWN_WR;
      else if (a[15:13] == 3'b011) return RG_PEER_RD;
      else if (a[15:8] == 8'h80)   return RG_IO;
      else if (a == ID_ADDR)       return RG_ID;
      else                         return RG_NONE;
   endfunction

endpackage

// File: rtl/fabric_phase_gen.sv
module fabric_phase_gen (
   input  logic clk,
   input  logic rst_n,
   output logic phase_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_o <= 1'b0;
      else        phase_o <= ~phase_o;
   end
endmodule

// File: rtl/fabric_decode.sv
module fabric_decode
   import fabric_pkg::*;
(
   input  logic [ADDR_W-1:0] addr_i,
   output region_e           region_o
);
   always_comb region_o = decode_region(addr_i);
endmodule

// File: rtl/fabric_bank.sv
module fabric_bank #(
   parameter int AW = 9,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/dual_phase_mem_fabric.sv
module dual_phase_mem_fabric
   import fabric_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int BANK_AW  = 9,
   parameter int IO_CORE  = 0,
   parameter int IRQ_CORE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              phase,
   input  logic [15:0]       c0_addr,
   input  logic              c0_we,
   input  logic [DATA_W-1:0] c0_wdata,
   output logic [DATA_W-1:0] c0_rdata,
   output logic              c0_viol,
   output logic              c0_irq,
   input  logic [15:0]       c1_addr,
   input  logic              c1_we,
   input  logic [DATA_W-1:0] c1_wdata,
   output logic [DATA_W-1:0] c1_rdata,
   output logic              c1_viol,
   output logic              c1_irq,
   input  logic              irq_in,
   output logic              io_sel,
   output logic [7:0]        io_addr,
   output logic              io_we,
   output logic [DATA_W-1:0] io_wdata,
   input  logic [DATA_W-1:0] io_rdata
);

   localparam int   NCORE  = 2;
   localparam logic IO_BIT = 1'(IO_CORE);

   // elaboration-time parameter checks
   if (DATA_W < 1) begin : g_bad_dw
      $error("DATA_W must be at least 1");
   end
   if (BANK_AW < 1 || BANK_AW > 13) begin : g_bad_aw
      $error("BANK_AW must lie in 1..13 to fit the smallest window");
   end
   if (IO_CORE < 0 || IO_CORE > 1) begin : g_bad_io
      $error("IO_CORE must be 0 or 1");
   end
   if (IRQ_CORE < 0 || IRQ_CORE > 1) begin : g_bad_irq
      $error("IRQ_CORE must be 0 or 1");
   end

   fabric_phase_gen u_phase (.clk(clk), .rst_n(rst_n), .phase_o(phase));

   // owner-phase bus selection
   logic [15:0]       cur_addr;
   logic              cur_we;
   logic [DATA_W-1:0] cur_wdata;

   always_comb begin
      cur_addr  = phase ? c1_addr  : c0_addr;
      cur_we    = phase ? c1_we    : c0_we;
      cur_wdata = phase ? c1_wdata : c0_wdata;
   end

   region_e cur_rg;
   fabric_decode u_dec (.addr_i(cur_addr), .region_o(cur_rg));

   logic [BANK_AW-1:0] bidx;
   assign bidx = cur_addr[BANK_AW-1:0];

   logic [DATA_W-1:0] priv_rd [NCORE];
   logic [DATA_W-1:0] xb_rd   [NCORE];

   for (genvar g = 0; g < NCORE; g++) begin : g_core
      logic own;
      logic priv_we;
      logic xb_we;

      assign own     = (phase == 1'(g));
      assign priv_we = own && cur_we && (cur_rg == RG_PRIV);
      assign xb_we   = own && cur_we && (cur_rg == RG_OWN_WR);

      fabric_bank #(.AW(BANK_AW), .DW(DATA_W)) u_priv (
         .clk(clk), .we(priv_we), .addr(bidx),
         .wdata(cur_wdata), .rdata(priv_rd[g])
      );

      // crossover bank g: written by core g, read by the other core
      fabric_bank #(.AW(BANK_AW), .DW(DATA_W)) u_xbank (
         .clk(clk), .we(xb_we), .addr(bidx),
         .wdata(cur_wdata), .rdata(xb_rd[g])
      );
   end

   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      case (cur_rg)
         RG_PRIV:    rd_mux = priv_rd[phase];
         RG_PEER_RD: rd_mux = xb_rd[~phase];
         RG_ID:      rd_mux = DATA_W'(phase);
         RG_IO:      rd_mux = (phase == IO_BIT) ? io_rdata : '1;
         default:    rd_mux = '1;
      endcase
   end

   logic [DATA_W-1:0] rdata_q [NCORE];
   logic [NCORE-1:0]  viol_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NCORE; i++) rdata_q[i] <= '0;
         viol_q <= '0;
      end else begin
         if (!cur_we) rdata_q[phase] <= rd_mux;
         if (cur_we && (cur_rg == RG_PEER_RD)) viol_q[phase] <= 1'b1;
      end
   end

   assign c0_rdata = rdata_q[0];
   assign c1_rdata = rdata_q[1];
   assign c0_viol  = viol_q[0];
   assign c1_viol  = viol_q[1];

   // peripheral window pinned to one phase
   assign io_sel   = (phase == IO_BIT) && (cur_rg == RG_IO);
   assign io_we    = io_sel && cur_we;
   assign io_addr  = cur_addr[7:0];
   assign io_wdata = cur_wdata;

   // interrupt steering
   if (IRQ_CORE == 0) begin : g_irq0
      assign c0_irq = irq_in;
      assign c1_irq = 1'b0;
   end else begin : g_irq1
      assign c0_irq = 1'b0;
      assign c1_irq = irq_in;
   end

endmodule

// File: rtl/fabric_checker.sv
module fabric_checker #(
   parameter int DATA_W   = 8,
   parameter int IO_CORE  = 0,
   parameter int IRQ_CORE = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              phase,
   input logic [15:0]       c0_addr,
   input logic              c0_we,
   input logic [DATA_W-1:0] c0_rdata,
   input logic              c0_viol,
   input logic              c0_irq,
   input logic [15:0]       c1_addr,
   input logic              c1_we,
   input logic [DATA_W-1:0] c1_rdata,
   input logic              c1_viol,
   input logic              c1_irq,
   input logic              irq_in,
   input logic              io_sel
);
   localparam logic IO_BIT  = 1'(IO_CORE);
   localparam logic IRQ_BIT = 1'(IRQ_CORE);

   AST_PHASE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (phase != $past(phase)));                                    // R1

   AST_C0_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 1'b1) |=> $stable(c0_rdata));                               // R2

   AST_C1_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 1'b0) |=> $stable(c1_rdata));                               // R2

   AST_C0_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      c0_viol |=> c0_viol);                                                 // R6

   AST_C1_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      c1_viol |=> c1_viol);                                                 // R6

   AST_C0_VIOL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(c0_viol) |-> $past(phase == 1'b0 && c0_we && c0_addr[15:13] == 3'b011)); // R6

   AST_C1_VIOL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(c1_viol) |-> $past(phase == 1'b1 && c1_we && c1_addr[15:13] == 3'b011)); // R6

   AST_C0_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 1'b0 && !c0_we && c0_addr == 16'hFFF0) |=> (c0_rdata == '0)); // R7

   AST_C1_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 1'b1 && !c1_we && c1_addr == 16'hFFF0) |=> (c1_rdata == DATA_W'(1))); // R7

   AST_IO_OWNER_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      io_sel |-> (phase == IO_BIT));                                        // R8

   AST_IRQ_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      ((IRQ_BIT ? c1_irq : c0_irq) == irq_in) && !(IRQ_BIT ? c0_irq : c1_irq)); // R9

endmodule

bind dual_phase_mem_fabric fabric_checker #(
   .DATA_W(DATA_W), .IO_CORE(IO_CORE), .IRQ_CORE(IRQ_CORE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .phase(phase),
   .c0_addr(c0_addr), .c0_we(c0_we), .c0_rdata(c0_rdata),
   .c0_viol(c0_viol), .c0_irq(c0_irq),
   .c1_addr(c1_addr), .c1_we(c1_we), .c1_rdata(c1_rdata),
   .c1_viol(c1_viol), .c1_irq(c1_irq),
   .irq_in(irq_in), .io_sel(io_sel)
);

// File: tb/sim_dual_phase_mem_fabric.sv
module sim_dual_phase_mem_fabric;
   localparam int DW    = 8;
   localparam int AW    = 9;
   localparam int DEPTH = 1 << AW;
   localparam int IOC   = 0;
   localparam int IRQC  = 0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic phase;
   logic [15:0] c0_addr = '0, c1_addr = '0;
   logic c0_we = 1'b0, c1_we = 1'b0;
   logic [DW-1:0] c0_wdata = '0, c1_wdata = '0;
   logic [DW-1:0] c0_rdata, c1_rdata;
   logic c0_viol, c1_viol, c0_irq, c1_irq;
   logic irq_in = 1'b0;
   logic io_sel, io_we;
   logic [7:0] io_addr;
   logic [DW-1:0] io_wdata, io_rdata;

   always #10 clk = ~clk;

   assign io_rdata = ~io_addr ^ 8'h3C;

   dual_phase_mem_fabric #(.DATA_W(DW), .BANK_AW(AW), .IO_CORE(IOC), .IRQ_CORE(IRQC)) u0 (
      .clk(clk), .rst_n(rst_n), .phase(phase),
      .c0_addr(c0_addr), .c0_we(c0_we), .c0_wdata(c0_wdata), .c0_rdata(c0_rdata),
      .c0_viol(c0_viol), .c0_irq(c0_irq),
      .c1_addr(c1_addr), .c1_we(c1_we), .c1_wdata(c1_wdata), .c1_rdata(c1_rdata),
      .c1_viol(c1_viol), .c1_irq(c1_irq),
      .irq_in(irq_in), .io_sel(io_sel), .io_addr(io_addr), .io_we(io_we),
      .io_wdata(io_wdata), .io_rdata(io_rdata)
   );

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   logic [7:0] m_priv [2][DEPTH];
   logic [7:0] m_xb   [2][DEPTH];
   logic [7:0] exp_r  [2];
   bit         exp_viol [2];
   int         exp_io_n = 0;
   logic [7:0] exp_io_a, exp_io_d;

   int         io_cnt = 0, bad_io = 0;
   logic [7:0] io_la, io_ld;

   always @(posedge clk) begin
      if (rst_n && io_sel && io_we) begin
         io_cnt <= io_cnt + 1;
         io_la  <= io_addr;
         io_ld  <= io_wdata;
      end
   end

   always @(negedge clk) begin
      #2;
      if (rst_n && io_sel && phase !== 1'(IOC)) bad_io++;
   end

   task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic string tag_of(input logic [15:0] a);
      if (a < 16'h4000)      return "R3";
      else if (a < 16'h6000) return "R5";
      else if (a < 16'h8000) return "R4";
      else if (a < 16'h8100) return "R8";
      else if (a == 16'hFFF0) return "R7";
      else                   return "R10";
   endfunction

   function automatic logic [7:0] exp_rd(input int c, input logic [15:0] a);
      int i = int'(a[AW-1:0]);
      if (a < 16'h4000)       return m_priv[c][i];
      else if (a < 16'h6000)  return 8'hFF;
      else if (a < 16'h8000)  return m_xb[1-c][i];
      else if (a < 16'h8100)  return (c == IOC) ? (~a[7:0] ^ 8'h3C) : 8'hFF;
      else if (a == 16'hFFF0) return 8'(c);
      else                    return 8'hFF;
   endfunction

   task automatic exp_wr(input int c, input logic [15:0] a, input logic [7:0] d);
      int i = int'(a[AW-1:0]);
      if (a < 16'h4000)      m_priv[c][i] = d;
      else if (a < 16'h6000) m_xb[c][i] = d;
      else if (a < 16'h8000) exp_viol[c] = 1'b1;
      else if (a < 16'h8100 && c == IOC) begin
         exp_io_n++;
         exp_io_a = a[7:0];
         exp_io_d = d;
      end
   endtask

   // one phase for each core; the idle core always drives random writes (R1)
   task automatic pair(input logic [15:0] a0, input logic w0, input logic [7:0] d0,
                       input logic [15:0] a1, input logic w1, input logic [7:0] d1);
      while (phase !== 1'b0) @(negedge clk);
      c0_addr = a0; c0_we = w0; c0_wdata = d0;
      c1_addr = 16'($urandom); c1_we = 1'b1; c1_wdata = 8'($urandom);
      if (!w0) exp_r[0] = exp_rd(0, a0); else exp_wr(0, a0, d0);
      @(negedge clk);
      chk(c0_rdata === exp_r[0], w0 ? "R2" : tag_of(a0), 16'(c0_rdata), 16'(exp_r[0]));
      c1_addr = a1; c1_we = w1; c1_wdata = d1;
      c0_addr = 16'($urandom); c0_we = 1'b1; c0_wdata = 8'($urandom);
      if (!w1) exp_r[1] = exp_rd(1, a1); else exp_wr(1, a1, d1);
      @(negedge clk);
      chk(c1_rdata === exp_r[1], w1 ? "R2" : tag_of(a1), 16'(c1_rdata), 16'(exp_r[1]));
      chk(c0_rdata === exp_r[0], "R2 hold", 16'(c0_rdata), 16'(exp_r[0]));
      chk({c1_viol, c0_viol} === {exp_viol[1], exp_viol[0]}, "R6 flags",
          16'({c1_viol, c0_viol}), 16'({exp_viol[1], exp_viol[0]}));
      c0_we = 1'b0; c1_we = 1'b0;
   endtask

   function automatic logic [15:0] rnd_addr();
      case ($urandom % 8)
         0, 1:    return {2'b00, 14'($urandom)};
         2, 3:    return {3'b010, 13'($urandom)};
         4, 5:    return {3'b011, 13'($urandom)};
         6:       return {8'h80, 8'($urandom)};
         default: return ($urandom % 2) ? 16'hFFF0 : 16'h9000 + 16'($urandom % 16'h1000);
      endcase
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      n_err++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      exp_r[0] = '0; exp_r[1] = '0;
      exp_viol[0] = 1'b0; exp_viol[1] = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      // reset state
      chk(phase === 1'b0, "R1 reset phase", 16'(phase), 16'h0);
      chk(c0_rdata === '0 && c1_rdata === '0, "R2 reset rdata", {c0_rdata, c1_rdata}, 16'h0);
      chk(!c0_viol && !c1_viol, "R6 reset flags", 16'({c1_viol, c0_viol}), 16'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // interrupt routing
      irq_in = 1'b1; #1;
      chk(c0_irq === 1'b1 && c1_irq === 1'b0, "R9 irq high", 16'({c1_irq, c0_irq}), 16'h1);
      irq_in = 1'b0; #1;
      chk(c0_irq === 1'b0 && c1_irq === 1'b0, "R9 irq low", 16'({c1_irq, c0_irq}), 16'h0);

      // fill every bank
      for (int i = 0; i < DEPTH; i++)
         pair(16'(i), 1'b1, 8'($urandom), 16'(i), 1'b1, 8'($urandom));
      for (int i = 0; i < DEPTH; i++)
         pair(16'h4000 + 16'(i), 1'b1, 8'($urandom), 16'h4000 + 16'(i), 1'b1, 8'($urandom));

      // R4 back-to-back writes to the same crossover index, then cross reads
      pair(16'h4005, 1'b1, 8'hAA, 16'h4005, 1'b1, 8'h55);
      pair(16'h6005, 1'b0, 8'h00, 16'h6005, 1'b0, 8'h00);
      chk(c0_rdata === 8'h55 && c1_rdata === 8'hAA, "R4 crossover",
          {c0_rdata, c1_rdata}, 16'h55AA);
      // R5 own write window reads all ones
      pair(16'h4005, 1'b0, 8'h00, 16'h5FFF, 1'b0, 8'h00);
      chk(c0_rdata === 8'hFF && c1_rdata === 8'hFF, "R5", {c0_rdata, c1_rdata}, 16'hFFFF);
      // R6 illegal write by core 1 only
      pair(16'h0001, 1'b0, 8'h00, 16'h6005, 1'b1, 8'h11);
      chk(c1_viol === 1'b1 && c0_viol === 1'b0, "R6 set", 16'({c1_viol, c0_viol}), 16'h2);
      pair(16'h0001, 1'b0, 8'h00, 16'h6005, 1'b0, 8'h00);
      chk(c1_rdata === 8'hAA, "R6 no store", 16'(c1_rdata), 16'h00AA);
      // R3 aliasing and privacy
      pair(16'(DEPTH + 3), 1'b1, 8'h3C, 16'h0003, 1'b1, 8'hC3);
      pair(16'h0003, 1'b0, 8'h00, 16'(DEPTH + 3), 1'b0, 8'h00);
      chk(c0_rdata === 8'h3C && c1_rdata === 8'hC3, "R3 alias", {c0_rdata, c1_rdata}, 16'h3CC3);
      // R7 identity, write ignored
      pair(16'hFFF0, 1'b1, 8'h77, 16'hFFF0, 1'b1, 8'h77);
      pair(16'hFFF0, 1'b0, 8'h00, 16'hFFF0, 1'b0, 8'h00);
      chk(c0_rdata === 8'h00 && c1_rdata === 8'h01, "R7 id", {c0_rdata, c1_rdata}, 16'h0001);
      // R8 peripheral window from owner and non-owner
      pair(16'h8012, 1'b1, 8'h77, 16'h8013, 1'b1, 8'h99);
      chk(io_cnt == exp_io_n && io_la === 8'h12 && io_ld === 8'h77, "R8 io write",
          16'(io_cnt), 16'(exp_io_n));
      pair(16'h8020, 1'b0, 8'h00, 16'h8020, 1'b0, 8'h00);
      chk(c1_rdata === 8'hFF, "R8 non-owner read", 16'(c1_rdata), 16'h00FF);
      // R10 unmapped address
      pair(16'h9000, 1'b1, 8'h12, 16'hA000, 1'b1, 8'h34);
      pair(16'h9000, 1'b0, 8'h00, 16'hA000, 1'b0, 8'h00);
      chk(c0_rdata === 8'hFF && c1_rdata === 8'hFF, "R10", {c0_rdata, c1_rdata}, 16'hFFFF);

      // random interleaved traffic
      for (int n = 0; n < 3000; n++)
         pair(rnd_addr(), 1'($urandom), 8'($urandom), rnd_addr(), 1'($urandom), 8'($urandom));

      chk(io_cnt == exp_io_n, "R8 io count", 16'(io_cnt), 16'(exp_io_n));
      if (exp_io_n > 0)
         chk(io_la === exp_io_a && io_ld === exp_io_d, "R8 io last",
             {io_la, io_ld}, {exp_io_a, exp_io_d});
      chk(bad_io == 0, "R8 io phase", 16'(bad_io), 16'h0);
      chk(phase !== 1'bx, "R1 phase defined", 16'(phase), 16'h0);
      finish_run();
   end
endmodule